// File: doc/BRIEF.md
# Clock Request Output Gating Controller

This block decides which of a bank of SRC clock outputs are running, based on two active-low clock-request pins that arrive with no timing relation to the SRC clock. A mapping register binds each output to request line A, to request line B, to both, or to neither. An output bound to no line runs all the time. An output bound to one or both lines runs while any of its lines holds an accepted low level.

Each request pin first passes through a two-flop synchroniser. A new level then counts only after it has held through two consecutive SRC rising edges. This filters out short pulses.

Gate enables are registered on the falling edge of the SRC clock. Each gated output is the SRC clock ANDed with its enable, so an output starts or stops only while the clock is low. No output ever shows a shortened high or low phase.

Top module: `clkreq_gate_ctrl`

## Requirements
- R1: A request line whose accepted level is low makes every output bound to it run, with its enable bit at 1. An accepted high level stops every output bound only to that line, with its enable bit at 0.
- R2: Each request pin is synchronised through two flops. A new level is accepted only once the synchronised value is equal on two consecutive SRC rising edges. A low pulse shorter than one SRC period never changes any output.
- R3: The mapping register is written from `map_wdata_i` on a rising edge while `map_we_i` is 1. Bit i binds output i to line A. Bit N_OUT+i binds output i to line B.
- R4: An output with both of its mapping bits clear keeps its enable at 1 whatever the request pins do.
- R5: An output bound to both lines runs while either accepted request is low, and stops only when both are high.
- R6: A held change on a request pin reaches the enable of each output bound to it after at least 2 and at most 6 SRC periods, for both starting and stopping.
- R7: Enables change only on falling SRC edges, and each gated clock is the SRC clock ANDed with its enable. No gated output shows a high or low phase shorter than half an SRC period.
- R8: Reset clears all mapping bits, sets both accepted request levels to high, and drives every enable to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | SRC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_a_ni | input | 1 | Request line A, active low, asynchronous |
| req_b_ni | input | 1 | Request line B, active low, asynchronous |
| map_we_i | input | 1 | Mapping register write strobe |
| map_wdata_i | input | 2*N_OUT | Mapping write data; low half is line A, high half is line B |
| out_en_o | output | N_OUT | Per-output enable, updated on falling edges |
| clk_out_o | output | N_OUT | Gated SRC clock per output |

## Verification
The request pins are driven with long held levels and with sub-period low pulses placed at several phases against the clock edge. The long levels show that a held level is accepted and that its latency lands within the 2 to 6 period window. The short pulses separate a working stability filter from one that lets single samples through.

A mixed mapping puts outputs on line A only, on line B only, on both lines, and on neither. Walking the two lines through all four level combinations then shows OR behaviour on shared outputs and immunity on unbound ones. A monitor on every gated clock measures each high and low phase, so any cut phase shows up on its own.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;

    // synchroniser and filter state for one request line
    typedef struct packed {
        logic s1;   // first sync flop
        logic s2;   // second sync flop
        logic s3;   // previous synchronised sample
        logic acc;  // accepted level (active low)
    } dbnc_t;

    localparam int unsigned NUM_REQ = 2;

endpackage

// File: rtl/clkreq_debounce.sv
module clkreq_debounce
    import clkreq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_ni,
    output logic acc_no
);
    dbnc_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = req_ni;
        st_d.s2  = st_q.s1;
        st_d.s3  = st_q.s2;
        if (st_q.s2 == st_q.s3) begin
            st_d.acc = st_q.s2;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1, acc: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_no = st_q.acc;

    // R2
    accept_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.acc != $past(st_q.acc)) |-> ($past(st_q.s2) == $past(st_q.s3)));

endmodule

// File: rtl/clkreq_map.sv
module clkreq_map #(
    parameter int unsigned N_OUT = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 we_i,
    input  logic [2*N_OUT-1:0]   wdata_i,
    input  logic                 acc_a_ni,
    input  logic                 acc_b_ni,
    output logic [N_OUT-1:0]     map_a_o,
    output logic [N_OUT-1:0]     map_b_o,
    output logic [N_OUT-1:0]     want_o
);
    localparam int unsigned MAP_W = 2 * N_OUT;

    typedef struct packed {
        logic [MAP_W-1:0] bits;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (we_i) begin
            map_d.bits = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign map_a_o = map_q.bits[N_OUT-1:0];
    assign map_b_o = map_q.bits[MAP_W-1:N_OUT];

    for (genvar i = 0; i < N_OUT; i++) begin : g_want
        assign want_o[i] = ~(map_a_o[i] | map_b_o[i])
                         | (map_a_o[i] & ~acc_a_ni)
                         | (map_b_o[i] & ~acc_b_ni);
    end

    // R3
    map_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> ({map_b_o, map_a_o} == $past(wdata_i)));

endmodule

// File: rtl/clkreq_gate.sv
module clkreq_gate #(
    parameter int unsigned N_OUT = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_OUT-1:0] want_i,
    output logic [N_OUT-1:0] en_o,
    output logic [N_OUT-1:0] clk_o
);
    logic [N_OUT-1:0] en_d, en_q;
    logic [N_OUT-1:0] en_rise_q;

    always_comb begin
        en_d = want_i;
    end

    // falling-edge register: enables only move while the clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= '1;
        end else begin
            en_q <= en_d;
        end
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_gate
        assign clk_o[i] = clk_i & en_q[i];
    end

    assign en_o = en_q;

    // copy taken at each rising edge, compared during the high phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_rise_q <= '1;
        end else begin
            en_rise_q <= en_q;
        end
    end

    // R7
    en_hold_high_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
        en_q == en_rise_q);

endmodule

// File: rtl/clkreq_gate_ctrl.sv
module clkreq_gate_ctrl
    import clkreq_pkg::*;
#(
    parameter int unsigned N_OUT = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_a_ni,
    input  logic               req_b_ni,
    input  logic               map_we_i,
    input  logic [2*N_OUT-1:0] map_wdata_i,
    output logic [N_OUT-1:0]   out_en_o,
    output logic [N_OUT-1:0]   clk_out_o
);
    logic [NUM_REQ-1:0] req_n;
    logic [NUM_REQ-1:0] acc_n;
    logic [N_OUT-1:0]   map_a, map_b, want;

    assign req_n = {req_b_ni, req_a_ni};

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        clkreq_debounce u_dbnc (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_ni (req_n[g]),
            .acc_no (acc_n[g])
        );
    end

    clkreq_map #(.N_OUT(N_OUT)) u_map (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (map_we_i),
        .wdata_i  (map_wdata_i),
        .acc_a_ni (acc_n[0]),
        .acc_b_ni (acc_n[1]),
        .map_a_o  (map_a),
        .map_b_o  (map_b),
        .want_o   (want)
    );

    clkreq_gate #(.N_OUT(N_OUT)) u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .want_i (want),
        .en_o   (out_en_o),
        .clk_o  (clk_out_o)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        // R4
        unmapped_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(map_a[i] | map_b[i]) |-> out_en_o[i]);
    end

endmodule

// File: tb/tb_clkreq_gate_ctrl.sv
`timescale 1ns/1ps
module tb_clkreq_gate_ctrl;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_a_n = 1'b1;
    logic           req_b_n = 1'b1;
    logic           we = 1'b0;
    logic [2*N-1:0] wdata = '0;
    logic [N-1:0]   en;
    logic [N-1:0]   gclk;

    int total = 0;
    int bad = 0;
    int runts = 0;
    int rises = 0;

    always #2.5 clk = ~clk;

    clkreq_gate_ctrl #(.N_OUT(N)) dut (
        .clk_i(clk), .rst_ni(rst_n), .req_a_ni(req_a_n), .req_b_ni(req_b_n),
        .map_we_i(we), .map_wdata_i(wdata), .out_en_o(en), .clk_out_o(gclk)
    );

    // phase-width monitor on every gated clock (R7)
    for (genvar i = 0; i < N; i++) begin : g_mon
        realtime t_up = 0.0;
        realtime t_dn = 0.0;
        always @(posedge gclk[i]) begin
            if (rst_n && t_dn > 0.0 && ($realtime - t_dn) < 2.4) runts++;
            t_up = $realtime;
            rises++;
        end
        always @(negedge gclk[i]) begin
            if (rst_n && t_up > 0.0 && ($realtime - t_up) < 2.4) runts++;
            t_dn = $realtime;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic wr_map(input logic [2*N-1:0] v);
        @(posedge clk); #1;
        we = 1'b1; wdata = v;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    // count periods until en[bit] reaches lvl; caller drives pin right after a posedge+1
    task automatic lat(input int bit_i, input logic lvl, output int k);
        k = 99;
        for (int c = 1; c <= 10; c++) begin
            @(posedge clk); #1;
            if (en[bit_i] == lvl && k == 99) k = c;
        end
    endtask

    task automatic t_reset();
        cyc(3);
        chk(en == 8'hFF, "R8 reset enables", en, 8'hFF);
    endtask

    task automatic t_unmapped();
        req_a_n = 1'b0; req_b_n = 1'b0; cyc(8);
        chk(en == 8'hFF, "R4 unmapped with requests low", en, 8'hFF);
        req_a_n = 1'b1; req_b_n = 1'b1; cyc(8);
        chk(en == 8'hFF, "R4 unmapped with requests high", en, 8'hFF);
    endtask

    task automatic t_map();
        // A: outputs 0-3 and 6; B: outputs 4,5,6; output 7 unmapped
        wr_map(16'h704F); cyc(3);
        chk(en == 8'h80, "R3 mapping with both idle", en, 8'h80);
    endtask

    task automatic t_start_a();
        int k;
        req_a_n = 1'b0;
        lat(0, 1'b1, k);
        chk(k >= 2 && k <= 6, "R6 start latency", k, 5);
        chk(en == 8'hCF, "R1 line A low", en, 8'hCF);
    endtask

    task automatic t_short();
        for (int p = 0; p < 4; p++) begin
            @(posedge clk); #(0.5 + p);
            req_b_n = 1'b0; #3.0; req_b_n = 1'b1;
            cyc(7);
            chk(en == 8'hCF, "R2 short pulse rejected", en, 8'hCF);
        end
    endtask

    task automatic t_stop_and_both();
        int k;
        req_a_n = 1'b1;
        lat(0, 1'b0, k);
        chk(k >= 2 && k <= 6, "R6 stop latency", k, 5);
        chk(en == 8'h80, "R1 line A high", en, 8'h80);
        req_b_n = 1'b0; cyc(8);
        chk(en == 8'hF0, "R5 shared via B", en, 8'hF0);
        req_a_n = 1'b0; cyc(8);
        chk(en == 8'hFF, "R5 both low", en, 8'hFF);
        req_b_n = 1'b1; cyc(8);
        chk(en == 8'hCF, "R5 shared via A", en, 8'hCF);
        req_a_n = 1'b1; cyc(8);
        chk(en == 8'h80, "R5 both high stops shared", en, 8'h80);
    endtask

    task automatic t_remap();
        wr_map('0); cyc(3);
        chk(en == 8'hFF, "R3 cleared mapping", en, 8'hFF);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #12.5 rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_map();
        t_start_a();
        t_short();
        t_stop_and_both();
        t_remap();
        chk(runts == 0, "R7 no runt phases", runts, 0);
        chk(rises > 100, "R7 gated clocks toggle", rises, 100);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule